// File: doc/BRIEF.md
# Phase Build-Out Reference Switcher

This block chooses one active timing reference out of several candidate input clocks and keeps the phase step caused by a change of reference from reaching the downstream loop filter. Each cycle is one phase sample. For every input it receives a valid flag, a 4-bit priority and a signed phase error measured against the local output phase. It drives the index of the selected input, a corrected phase error for the loop filter, the build-out offset currently subtracted, and a one-hot mode indication: locked, lost-phase or holdover.

At each switch away from a locked reference the block stores the phase step between the new and old reference, added to the offset it already held, so that the corrected error stays continuous. A small control register turns the build-out on or off and can freeze it. When frozen, later switches keep the held offset instead of recapturing one. When off, the offset is cleared and the loop slews back to zero phase error. A captured offset is rounded down to a multiple of 2^QUANT_SH, which models the small residual step left at each switch.

The state machine has three states. ST_HOLD is entered from reset and whenever no input is eligible. ST_LOST is a timed lost-phase window that follows any new selection. ST_LOCK is normal tracking. The transitions are: HOLD→LOST when an input becomes eligible (select best, no capture); LOST→LOST when the selected input drops and another is eligible (reselect, restart the window, no capture); LOST→LOCK when the window count runs out; LOST→HOLD and LOCK→HOLD when no input is eligible; LOCK→LOST when the selected input drops and another is eligible (select best, capture offset).

Top module: `pbo_ref_switch`

## Requirements
- R1: After reset the block is in holdover with selected index 0, offset 0 and corrected error 0, and the control register holds enable=1 and freeze=0.
- R2: An input is eligible when its valid flag is 1 and its priority is nonzero. The best input has the lowest nonzero priority value, and on equal priority the lower index wins.
- R3: While locked to an eligible input, a better input that becomes eligible does not change the selection (non-revertive).
- R4: When a selection is made, the block shows lost-phase mode with corrected error 0 for lost_len+1 cycles and then enters locked mode.
- R5: When the selected input stops being eligible in locked mode and enable=1 with freeze=0, the next offset is (phase[new] − phase[old] + offset) rounded down to a multiple of 2^QUANT_SH, modulo 2^PH_W, using the samples of the switch cycle.
- R6: In locked mode the corrected error equals phase[selected] − offset, modulo 2^PH_W.
- R7: With control bits enable=1 and freeze=1 (bit 0 and bit 1), a switch selects the new input and enters lost-phase mode but keeps the held offset.
- R8: With enable=0 the offset reads 0 from the cycle after enable is seen cleared, freeze has no effect, and no switch captures an offset.
- R9: When no input is eligible the block enters holdover: the selected index and the offset are kept, and the corrected error is 0.
- R10: Leaving holdover selects the best eligible input and enters lost-phase mode without changing the offset.
- R11: A control write (reg_wr=1) loads reg_wdata bit 0 as enable and bit 1 as freeze at that clock edge. Bits 7 to 2 are ignored.
- R12: If the selected input stops being eligible during lost-phase mode and another is eligible, the best one is selected, the offset is unchanged and the lost-phase window restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_ok | input | N_REF | Per-input valid flags |
| ref_prio | input | N_REF*4 | Per-input priority, input i at bits [4i+3:4i], 0 = disabled |
| ref_phase | input | N_REF*PH_W | Per-input signed phase error, input i at bits [PH_W*i +: PH_W] |
| lost_len | input | LOST_W | Lost-phase window length minus one |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control write data: bit 0 enable, bit 1 freeze |
| sel_idx | output | $clog2(N_REF) | Selected input index |
| corr_err | output | PH_W | Corrected phase error to the loop filter |
| pbo_offset | output | PH_W | Build-out offset currently applied |
| mode_locked | output | 1 | Locked mode |
| mode_lost | output | 1 | Lost-phase mode |
| holdover | output | 1 | No eligible input |

## Verification
The bench builds the block with four inputs, a 12-bit phase word and a quantisation shift of 2, so the offset arithmetic wraps and rounds within a range that is easy to compute. With four inputs, every one of the 16 valid-flag masks can be applied under two priority sets, one with a tie and one with a disabled input, and each selection is compared with a best-input search written in the bench. A three-bit window length of 3 keeps each lost-phase window at four cycles. This lets twenty chained switches with varied phase steps be checked against the wrap-and-round formula, together with the freeze, disable and mid-window reselection cases.

// File: rtl/pbo_sw_pkg.sv
package pbo_sw_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_LOST = 2'd1,
        ST_LOCK = 2'd2
    } sw_state_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_FRZ_BIT = 1;
    localparam int PRIO_W       = 4;

endpackage

// File: rtl/pbo_prio_pick.sv
module pbo_prio_pick
    import pbo_sw_pkg::*;
#(
    parameter int N_REF = 4,
    localparam int IW   = (N_REF > 1) ? $clog2(N_REF) : 1
) (
    input  logic [N_REF-1:0]        ok,
    input  logic [N_REF*PRIO_W-1:0] prio,
    output logic [N_REF-1:0]        eligible,
    output logic                    any_ok,
    output logic [IW-1:0]           best_idx
);

    logic [PRIO_W-1:0] prio_a [N_REF];

    for (genvar g = 0; g < N_REF; g++) begin : g_unpack
        assign prio_a[g]   = prio[g*PRIO_W +: PRIO_W];
        assign eligible[g] = ok[g] && (prio_a[g] != '0);
    end

    logic [PRIO_W-1:0] best_p;

    always_comb begin
        any_ok   = 1'b0;
        best_idx = '0;
        best_p   = '1;
        for (int i = 0; i < N_REF; i++) begin
            if (eligible[i] && (!any_ok || prio_a[i] < best_p)) begin
                any_ok   = 1'b1;
                best_idx = IW'(i);
                best_p   = prio_a[i];
            end
        end
    end

endmodule

// File: rtl/pbo_ctrl_reg.sv
module pbo_ctrl_reg
    import pbo_sw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic       pbo_en,
    output logic       pbo_frz
);

    logic [1:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= 2'b01;
        end else if (wr) begin
            ctrl_q <= {wdata[CTRL_FRZ_BIT], wdata[CTRL_EN_BIT]};
        end
    end

    assign pbo_en  = ctrl_q[0];
    assign pbo_frz = ctrl_q[1] & ctrl_q[0];

    a_r11_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (pbo_en == $past(wdata[CTRL_EN_BIT])));

    a_r8_frz_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (!pbo_en) |-> (!pbo_frz));

endmodule

// File: rtl/pbo_offset_unit.sv
module pbo_offset_unit #(
    parameter int PH_W     = 16,
    parameter int QUANT_SH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pbo_en,
    input  logic            pbo_frz,
    input  logic            capture,
    input  logic [PH_W-1:0] new_ph,
    input  logic [PH_W-1:0] old_ph,
    output logic [PH_W-1:0] offset
);

    localparam logic [PH_W-1:0] QMASK = ~(PH_W'((1 << QUANT_SH) - 1));

    logic [PH_W-1:0] step_sum;
    logic [PH_W-1:0] step_q;

    always_comb begin
        step_sum = offset + new_ph - old_ph;
        step_q   = step_sum & QMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset <= '0;
        end else if (!pbo_en) begin
            offset <= '0;
        end else if (capture && !pbo_frz) begin
            offset <= step_q;
        end
    end

    a_r7_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pbo_en && pbo_frz) |=> $stable(offset));

    a_r8_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!pbo_en) |=> (offset == '0));

    a_r5_no_capture_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pbo_en && !capture) |=> $stable(offset));

endmodule

// File: rtl/pbo_ref_switch.sv
module pbo_ref_switch
    import pbo_sw_pkg::*;
#(
    parameter int N_REF    = 4,
    parameter int PH_W     = 16,
    parameter int QUANT_SH = 2,
    parameter int LOST_W   = 4,
    localparam int IW      = (N_REF > 1) ? $clog2(N_REF) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_REF-1:0]        ref_ok,
    input  logic [N_REF*4-1:0]      ref_prio,
    input  logic [N_REF*PH_W-1:0]   ref_phase,
    input  logic [LOST_W-1:0]       lost_len,
    input  logic                    reg_wr,
    input  logic [7:0]              reg_wdata,
    output logic [IW-1:0]           sel_idx,
    output logic [PH_W-1:0]         corr_err,
    output logic [PH_W-1:0]         pbo_offset,
    output logic                    mode_locked,
    output logic                    mode_lost,
    output logic                    holdover
);

    logic [N_REF-1:0] eligible;
    logic             any_ok;
    logic [IW-1:0]    best_idx;
    logic             pbo_en;
    logic             pbo_frz;

    pbo_prio_pick #(.N_REF(N_REF)) u_pick (
        .ok       (ref_ok),
        .prio     (ref_prio),
        .eligible (eligible),
        .any_ok   (any_ok),
        .best_idx (best_idx)
    );

    pbo_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .pbo_en  (pbo_en),
        .pbo_frz (pbo_frz)
    );

    logic [PH_W-1:0] ph_a [N_REF];
    for (genvar g = 0; g < N_REF; g++) begin : g_ph
        assign ph_a[g] = ref_phase[g*PH_W +: PH_W];
    end

    sw_state_e       st_q, st_d;
    logic [IW-1:0]   sel_q, sel_d;
    logic [LOST_W-1:0] cnt_q, cnt_d;
    logic            cap;

    // next-state process
    always_comb begin
        st_d  = st_q;
        sel_d = sel_q;
        cnt_d = cnt_q;
        cap   = 1'b0;
        unique case (st_q)
            ST_HOLD: begin
                if (any_ok) begin
                    st_d  = ST_LOST;
                    sel_d = best_idx;
                    cnt_d = lost_len;
                end
            end
            ST_LOST: begin
                if (!eligible[sel_q]) begin
                    if (any_ok) begin
                        sel_d = best_idx;
                        cnt_d = lost_len;
                    end else begin
                        st_d = ST_HOLD;
                    end
                end else if (cnt_q == '0) begin
                    st_d = ST_LOCK;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_LOCK: begin
                if (!eligible[sel_q]) begin
                    if (any_ok) begin
                        st_d  = ST_LOST;
                        sel_d = best_idx;
                        cnt_d = lost_len;
                        cap   = 1'b1;
                    end else begin
                        st_d = ST_HOLD;
                    end
                end
            end
            default: st_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_HOLD;
            sel_q <= '0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            sel_q <= sel_d;
            cnt_q <= cnt_d;
        end
    end

    pbo_offset_unit #(.PH_W(PH_W), .QUANT_SH(QUANT_SH)) u_off (
        .clk     (clk),
        .rst_n   (rst_n),
        .pbo_en  (pbo_en),
        .pbo_frz (pbo_frz),
        .capture (cap),
        .new_ph  (ph_a[best_idx]),
        .old_ph  (ph_a[sel_q]),
        .offset  (pbo_offset)
    );

    // output process
    always_comb begin
        mode_locked = 1'b0;
        mode_lost   = 1'b0;
        holdover    = 1'b0;
        corr_err    = '0;
        unique case (st_q)
            ST_HOLD: holdover = 1'b1;
            ST_LOST: mode_lost = 1'b1;
            ST_LOCK: begin
                mode_locked = 1'b1;
                corr_err    = ph_a[sel_q] - pbo_offset;
            end
            default: holdover = 1'b1;
        endcase
    end

    assign sel_idx = sel_q;

    a_r4_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({mode_locked, mode_lost, holdover}));

    a_r3_locked_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_locked && eligible[sel_idx]) |=> (mode_locked && $stable(sel_idx)));

    a_r9_hold_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (holdover && !any_ok) |=> (holdover && $stable(sel_idx)));

    a_r4_loss_to_lost: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_locked && !eligible[sel_idx] && any_ok) |=> mode_lost);

    a_r10_exit_hold_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (holdover && any_ok && pbo_en) |=> (mode_lost && $stable(pbo_offset)));

endmodule

// File: tb/pbo_ref_switch_test.sv
module pbo_ref_switch_test;

    localparam int N  = 4;
    localparam int PW = 12;
    localparam int Q  = 2;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  ref_ok = '0;
    logic [3:0]    pr [N];
    logic [PW-1:0] ph [N];
    logic [N*4-1:0]  ref_prio;
    logic [N*PW-1:0] ref_phase;
    logic [LW-1:0] lost_len = 3'd3;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [1:0]    sel_idx;
    logic [PW-1:0] corr_err, pbo_offset;
    logic          mode_locked, mode_lost, holdover;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ref_prio[i*4 +: 4]   = pr[i];
            ref_phase[i*PW +: PW] = ph[i];
        end
    end

    pbo_ref_switch #(.N_REF(N), .PH_W(PW), .QUANT_SH(Q), .LOST_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .ref_prio(ref_prio),
        .ref_phase(ref_phase), .lost_len(lost_len), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .sel_idx(sel_idx), .corr_err(corr_err),
        .pbo_offset(pbo_offset), .mode_locked(mode_locked),
        .mode_lost(mode_lost), .holdover(holdover)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int best_of(input logic [N-1:0] ok);
        int b = -1;
        for (int i = 0; i < N; i++)
            if (ok[i] && pr[i] != 0 && (b < 0 || pr[i] < pr[b])) b = i;
        return b;
    endfunction

    function automatic logic [PW-1:0] quant(input logic [PW-1:0] v);
        return v & ~(PW'((1 << Q) - 1));
    endfunction

    task automatic wr_ctrl(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    // waits through a lost-phase window of lost_len+1 cycles
    task automatic ride_lost(input string tag);
        for (int c = 0; c <= int'(lost_len); c++) begin
            chk({tag, " lost"}, int'(mode_lost), 1);
            chk({tag, " corr0"}, int'(corr_err), 0);
            tick();
        end
        chk({tag, " locked"}, int'(mode_locked), 1);
    endtask

    task automatic sweep_masks(input string tag);
        int held = int'(sel_idx);
        for (int m = 0; m < 16; m++) begin
            int b;
            ref_ok = 4'(m);
            tick();
            b = best_of(4'(m));
            if (b < 0) begin
                chk({tag, " R9 hold"}, int'(holdover), 1);
                chk({tag, " R9 sel kept"}, int'(sel_idx), held);
            end else begin
                chk({tag, " R2 sel"}, int'(sel_idx), b);
                chk({tag, " R10 lost"}, int'(mode_lost), 1);
                chk({tag, " R10 offset"}, int'(pbo_offset), 0);
                held = b;
            end
            ref_ok = '0;
            tick();
            chk({tag, " R9 back"}, int'(holdover), 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [PW-1:0] off_m;
        int cur, nb;
        for (int i = 0; i < N; i++) begin pr[i] = 4'(i + 1); ph[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 hold", int'(holdover), 1);
        chk("R1 sel", int'(sel_idx), 0);
        chk("R1 offset", int'(pbo_offset), 0);
        chk("R1 corr", int'(corr_err), 0);

        // R2 / R10 / R9 selection sweeps, tie and disabled input
        pr[0] = 4'd3; pr[1] = 4'd1; pr[2] = 4'd1; pr[3] = 4'd0;
        sweep_masks("setA");
        pr[0] = 4'd7; pr[1] = 4'd0; pr[2] = 4'd9; pr[3] = 4'd2;
        sweep_masks("setB");

        // R4 window and R6 tracking
        for (int i = 0; i < N; i++) pr[i] = 4'(i + 1);
        ref_ok = '1;
        tick();
        chk("R2 R10 pick0", int'(sel_idx), 0);
        ride_lost("R4");
        for (int v = 0; v < 8; v++) begin
            ph[0] = PW'(v * 517 - 1200);
            #1;
            chk("R6 corr raw", int'(corr_err), int'(ph[0]));
        end

        // R5 chained captures, R3 non-revertive
        off_m = '0;
        cur = 0;
        for (int k = 0; k < 20; k++) begin
            for (int i = 0; i < N; i++) ph[i] = PW'(k * 97 + i * 331 - 500 + k * k * 13);
            ref_ok = '1;
            ref_ok[cur] = 1'b0;
            nb = best_of(ref_ok);
            tick();
            off_m = quant(ph[nb] - ph[cur] + off_m);
            chk("R5 sel", int'(sel_idx), nb);
            chk("R5 offset", int'(pbo_offset), int'(off_m));
            ref_ok = '1;
            ride_lost("R5");
            chk("R3 no revert", int'(sel_idx), nb);
            chk("R6 corr", int'(corr_err), int'(PW'(ph[nb] - off_m)));
            cur = nb;
        end

        // R7 freeze
        wr_ctrl(8'h03);
        ref_ok = '1; ref_ok[cur] = 1'b0;
        nb = best_of(ref_ok);
        tick();
        chk("R7 sel", int'(sel_idx), nb);
        chk("R7 lost", int'(mode_lost), 1);
        chk("R7 offset held", int'(pbo_offset), int'(off_m));
        ref_ok = '1;
        ride_lost("R7");
        cur = nb;

        // R8 disable (freeze bit ignored)
        wr_ctrl(8'h02);
        tick();
        chk("R8 offset zero", int'(pbo_offset), 0);
        chk("R8 corr raw", int'(corr_err), int'(ph[cur]));
        ref_ok[cur] = 1'b0;
        nb = best_of(ref_ok);
        tick();
        chk("R8 no capture", int'(pbo_offset), 0);
        ref_ok = '1;
        ride_lost("R8");
        cur = nb;

        // R11 upper bits ignored: enables, freeze clear
        wr_ctrl(8'hFD);
        ph[0] = 12'd40; ph[1] = 12'd903; ph[2] = 12'd3000; ph[3] = 12'd7;
        ref_ok[cur] = 1'b0;
        nb = best_of(ref_ok);
        tick();
        off_m = quant(ph[nb] - ph[cur]);
        chk("R11 capture on", int'(pbo_offset), int'(off_m));

        // R12 loss inside lost window
        tick();
        ref_ok = '1; ref_ok[nb] = 1'b0; ref_ok[cur] = 1'b0;
        cur = best_of(ref_ok);
        tick();
        chk("R12 reselect", int'(sel_idx), cur);
        chk("R12 offset kept", int'(pbo_offset), int'(off_m));
        ride_lost("R12");

        // R9 loss of everything while locked
        ref_ok = '0;
        tick();
        chk("R9 hold", int'(holdover), 1);
        chk("R9 sel", int'(sel_idx), cur);
        chk("R9 offset", int'(pbo_offset), int'(off_m));
        chk("R9 corr", int'(corr_err), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule